// File: doc/BRIEF.md
# USB 2.0 Transmit End-of-Packet and Inter-Packet Gap Timer

This block sits beside the transmit path of a USB 2.0 link controller on a UTMI-style PHY interface. When the packet sender reports that the last byte of a packet has been handed to the PHY, the block works out when that packet has actually ended on the wire. It then times the inter-packet gap that must pass before the next packet may start. Its only inputs are the two-bit line state, sampled at the PHY clock, and the transmit-done strobe.

The end of a packet is found in one of three ways. At full or low speed it is a single-ended-zero on the line state, taken either from one sample or, with glitch filtering on, from two consecutive samples. At high speed it is either the line going from J to idle, or a fixed delay of 40 bit times during which the line state is ignored. The gap that follows is a parameterised default length plus a 3-bit programmable extension. The speed, filter, fixed-delay and extension settings are quasi-static and are captured when a packet is accepted.

Top module: `usb2_tx_eop_timer`

## Requirements
- R1: Line state encoding is 00 = SE0, 01 = J, 10 = K, 11 = SE1. At FS/LS (cfg_hs = 0) with filtering off, the first line-state sample that is SE0 after an accepted tx_done ends the packet. Samples are taken at the clock edges after the accepting edge. eop_pulse is high for the one cycle that follows the clock edge that sampled that SE0.
- R2: At FS/LS with cfg_se0_filter = 1, SE0 must be sampled on two consecutive clock edges. A lone SE0 sample between non-SE0 samples is ignored. eop_pulse follows the edge of the second SE0 sample.
- R3: At HS (cfg_hs = 1) with cfg_fixed_end = 0, the end is a J sample immediately followed by an SE0 sample. SE0 preceded by anything other than J, including the first sample after acceptance, does not end the packet.
- R4: At HS with cfg_fixed_end = 1, the line state is ignored. eop_pulse follows the clock edge that is exactly END_BITS / BUS_W clock cycles (5 by default) after the edge that accepted tx_done.
- R5: Filtering has no effect at HS, and fixed-delay ending has no effect at FS/LS.
- R6: gap_done is a one-cycle pulse that follows the edge exactly BASE_GAP + cfg_gap_add cycles after the edge that produced eop_pulse (BASE_GAP = 4 by default, cfg_gap_add 0 to 7).
- R7: Speed, filter, fixed-delay and gap extension are captured on the edge that accepts tx_done. Changes to them while a packet or its gap is in progress have no effect on that packet.
- R8: tx_done is accepted only while idle, which is from reset or after gap_done. A strobe during end detection or during the gap is ignored, so each accepted packet gives exactly one eop_pulse and one gap_done.
- R9: SE1 (11) never counts as SE0 and never ends a packet, in any mode.
- R10: Synchronous reset (rst = 1) returns the block to idle with both outputs low. No pulse from a packet interrupted by reset follows later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hs | input | 1 | 1 = high speed, 0 = full/low speed |
| cfg_se0_filter | input | 1 | FS/LS: require two consecutive SE0 samples |
| cfg_fixed_end | input | 1 | HS: end packet after fixed delay instead of line state |
| cfg_gap_add | input | ADD_W (3) | Extra inter-packet gap cycles |
| tx_done | input | 1 | Last byte of packet handed to PHY |
| line_state | input | 2 | PHY line state (00 SE0, 01 J, 10 K, 11 SE1) |
| eop_pulse | output | 1 | One-cycle end-of-packet pulse |
| gap_done | output | 1 | One-cycle inter-packet gap complete pulse |

## Verification
eop_pulse is due one clock after the edge that sampled the qualifying line state, which is one register stage. In fixed-delay mode it is due five edges after the edge that accepted tx_done. gap_done is due BASE_GAP plus the extension edges after the eop edge. The bench starts each packet on a falling edge and indexes every following falling edge by the rising edges that have passed. It drives line-state sample k just before rising edge k and records the index at which each pulse is first seen. It then compares those indices with the expected edge counts for the mode and extension, and checks that each pulse occurred exactly once.

// File: rtl/usb2eop_pkg.sv
`timescale 1ns/1ps
package usb2eop_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GAP  = 2'd2
  } phase_t;

  typedef struct packed {
    logic hs;
    logic filt;
    logic fixed;
  } mode_t;

  // Bit times rounded up to whole interface clock cycles.
  function automatic int unsigned bits_to_cycles(int unsigned bits, int unsigned width);
    return (bits + width - 1) / width;
  endfunction

  // Total gap length in cycles.
  function automatic int unsigned gap_cycles(int unsigned base, int unsigned extra);
    return base + extra;
  endfunction

  // Width needed to hold values 0..maxval.
  function automatic int unsigned count_width(int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/usb2eop_line_qual.sv
`timescale 1ns/1ps
module usb2eop_line_qual
  import usb2eop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       sample,
  input  logic [1:0] ls,
  input  logic       hs,
  input  logic       filt,
  output logic       hit
);

  logic prev_se0_q;
  logic prev_j_q;
  logic is_se0;
  logic is_j;
  logic prior_ok;

  assign is_se0 = (ls == LS_SE0);
  assign is_j   = (ls == LS_J);

  // History of the previous sample taken in this packet.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_se0_q <= 1'b0;
      prev_j_q   <= 1'b0;
    end else if (sample) begin
      prev_se0_q <= is_se0;
      prev_j_q   <= is_j;
    end
  end

  always_comb begin
    if (hs)        prior_ok = prev_j_q;
    else if (filt) prior_ok = prev_se0_q;
    else           prior_ok = 1'b1;
  end

  assign hit = sample && is_se0 && prior_ok;

endmodule

// File: rtl/usb2eop_down_timer.sv
`timescale 1ns/1ps
module usb2eop_down_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expire = run && !load && (cnt_q == '0);

endmodule

// File: rtl/usb2_tx_eop_timer.sv
`timescale 1ns/1ps
module usb2_tx_eop_timer
  import usb2eop_pkg::*;
#(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned END_BITS = 40,
  parameter int unsigned BASE_GAP = 4,
  parameter int unsigned ADD_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hs,
  input  logic             cfg_se0_filter,
  input  logic             cfg_fixed_end,
  input  logic [ADD_W-1:0] cfg_gap_add,
  input  logic             tx_done,
  input  logic [1:0]       line_state,
  output logic             eop_pulse,
  output logic             gap_done
);

  localparam int unsigned DLY_CYC = bits_to_cycles(END_BITS, BUS_W);
  localparam int unsigned DLY_W   = count_width(DLY_CYC);
  localparam int unsigned GAP_MAX = gap_cycles(BASE_GAP, (1 << ADD_W) - 1);
  localparam int unsigned GAP_W   = count_width(GAP_MAX);

  phase_t           phase_q;
  mode_t            mode_q;
  logic [ADD_W-1:0] gap_add_q;

  // Named internal events.
  logic             tx_accept;
  logic             in_wait;
  logic             in_gap;
  logic             mode_hs;
  logic             filt_eff;
  logic             fixed_eff;
  logic             line_end;
  logic             dly_end;
  logic             pkt_end;
  logic             gap_end;
  logic [GAP_W-1:0] gap_total;

  assign tx_accept = (phase_q == ST_IDLE) && tx_done;
  assign in_wait   = (phase_q == ST_WAIT);
  assign in_gap    = (phase_q == ST_GAP);
  assign mode_hs   = mode_q.hs;
  assign filt_eff  = !mode_q.hs && mode_q.filt;
  assign fixed_eff = mode_q.hs && mode_q.fixed;
  assign gap_total = GAP_W'(gap_cycles(BASE_GAP, int'(gap_add_q)));

  usb2eop_line_qual u_qual (
    .clk    (clk),
    .rst    (rst),
    .clear  (tx_accept),
    .sample (in_wait && !fixed_eff),
    .ls     (line_state),
    .hs     (mode_hs),
    .filt   (filt_eff),
    .hit    (line_end)
  );

  usb2eop_down_timer #(.W(DLY_W)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (tx_accept),
    .load_val (DLY_W'(DLY_CYC - 1)),
    .run      (in_wait && fixed_eff),
    .expire   (dly_end)
  );

  assign pkt_end = in_wait && (fixed_eff ? dly_end : line_end);

  usb2eop_down_timer #(.W(GAP_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (pkt_end),
    .load_val (gap_total - GAP_W'(1)),
    .run      (in_gap),
    .expire   (gap_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= ST_IDLE;
      mode_q    <= '0;
      gap_add_q <= '0;
      eop_pulse <= 1'b0;
      gap_done  <= 1'b0;
    end else begin
      eop_pulse <= pkt_end;
      gap_done  <= gap_end;
      unique case (phase_q)
        ST_IDLE: if (tx_accept) begin
          phase_q   <= ST_WAIT;
          mode_q    <= '{hs: cfg_hs, filt: cfg_se0_filter, fixed: cfg_fixed_end};
          gap_add_q <= cfg_gap_add;
        end
        ST_WAIT: if (pkt_end) phase_q <= ST_GAP;
        ST_GAP:  if (gap_end) phase_q <= ST_IDLE;
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb2eop_checker.sv
`timescale 1ns/1ps
module usb2eop_checker #(
  parameter int unsigned DLY_CYC = 5,
  parameter int unsigned GAP_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             eop_pulse,
  input logic             gap_done,
  input logic [1:0]       line_state,
  input logic             tx_accept,
  input logic             mode_hs,
  input logic             filt_eff,
  input logic             fixed_eff,
  input logic [GAP_W-1:0] gap_total
);

  logic [7:0] since_acc;
  logic [7:0] since_eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_acc <= '0;
      since_eop <= '0;
    end else begin
      if (tx_accept)               since_acc <= '0;
      else if (since_acc != 8'hFF) since_acc <= since_acc + 8'd1;
      if (eop_pulse)               since_eop <= 8'd1;
      else if (since_eop != 8'hFF) since_eop <= since_eop + 8'd1;
    end
  end

  assert_fs_single_R1: assert property (@(posedge clk) disable iff (rst)
    (eop_pulse && !mode_hs && !filt_eff) |-> ($past(line_state) == 2'b00));

  assert_fs_double_R2: assert property (@(posedge clk) disable iff (rst)
    (eop_pulse && filt_eff) |-> ($past(line_state) == 2'b00 && $past(line_state, 2) == 2'b00));

  assert_hs_j_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (eop_pulse && mode_hs && !fixed_eff) |-> ($past(line_state) == 2'b00 && $past(line_state, 2) == 2'b01));

  assert_fixed_delay_R4: assert property (@(posedge clk) disable iff (rst)
    (eop_pulse && fixed_eff) |-> (since_acc == 8'(DLY_CYC)));

  assert_gap_length_R6: assert property (@(posedge clk) disable iff (rst)
    gap_done |-> (since_eop == 8'(gap_total)));

  assert_one_eop_R8: assert property (@(posedge clk) disable iff (rst)
    eop_pulse |=> !eop_pulse);

  assert_no_se1_R9: assert property (@(posedge clk) disable iff (rst)
    (eop_pulse && !fixed_eff) |-> ($past(line_state) != 2'b11));

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!eop_pulse && !gap_done));

endmodule

bind usb2_tx_eop_timer usb2eop_checker #(.DLY_CYC(DLY_CYC), .GAP_W(GAP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .eop_pulse  (eop_pulse),
  .gap_done   (gap_done),
  .line_state (line_state),
  .tx_accept  (tx_accept),
  .mode_hs    (mode_hs),
  .filt_eff   (filt_eff),
  .fixed_eff  (fixed_eff),
  .gap_total  (gap_total)
);

// File: tb/test_usb2_tx_eop_timer.sv
`timescale 1ns/1ps
module test_usb2_tx_eop_timer;

  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;
  localparam int BASE_GAP = 4;
  localparam int FIX_DLY  = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_hs, cfg_se0_filter, cfg_fixed_end;
  logic [2:0] cfg_gap_add;
  logic       tx_done;
  logic [1:0] line_state;
  logic       eop_pulse, gap_done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  usb2_tx_eop_timer i_usb2_tx_eop_timer (
    .clk(clk), .rst(rst), .cfg_hs(cfg_hs), .cfg_se0_filter(cfg_se0_filter),
    .cfg_fixed_end(cfg_fixed_end), .cfg_gap_add(cfg_gap_add), .tx_done(tx_done),
    .line_state(line_state), .eop_pulse(eop_pulse), .gap_done(gap_done)
  );

  function automatic logic [15:0] pat8(logic [1:0] a, logic [1:0] b, logic [1:0] c, logic [1:0] d,
                                       logic [1:0] e, logic [1:0] f, logic [1:0] g, logic [1:0] h);
    return {h, g, f, e, d, c, b, a};
  endfunction

  typedef struct packed {
    logic       hs;
    logic       filt;
    logic       fix;
    logic [2:0] gap;
    logic [15:0] pat;
    logic [7:0] e_eop;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 3'd0, pat8(K, J, K, SE0, J, J, J, J), 8'd4},
    '{1'b0, 1'b1, 1'b0, 3'd0, pat8(K, SE0, K, J, SE0, SE0, J, J), 8'd6},
    '{1'b0, 1'b1, 1'b0, 3'd3, pat8(SE0, SE0, J, J, J, J, J, J), 8'd2},
    '{1'b1, 1'b0, 1'b0, 3'd0, pat8(K, J, SE0, J, J, J, J, J), 8'd3},
    '{1'b1, 1'b0, 1'b0, 3'd7, pat8(SE0, K, SE0, J, J, SE0, J, J), 8'd6},
    '{1'b1, 1'b0, 1'b1, 3'd0, pat8(J, SE0, J, SE0, K, SE0, J, J), 8'd5},
    '{1'b1, 1'b0, 1'b1, 3'd5, pat8(SE0, SE0, SE0, SE0, SE0, SE0, SE0, SE0), 8'd5},
    '{1'b0, 1'b0, 1'b0, 3'd1, pat8(J, J, J, J, J, J, J, SE0), 8'd8}
  };

  task automatic check_int(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Drives one packet. At falling edge k (after rising edges E0..E(k-1)),
  // outputs reflect edge E(k-1); line sample k is then driven for edge Ek.
  task automatic run_pkt(logic hs, logic filt, logic fix, logic [2:0] g, logic [15:0] pat,
                         int chg_k, int extra_k, int e_eop, string tag);
    int eop_at = -1, gap_at = -1, n_eop = 0, n_gap = 0;
    @(negedge clk);
    cfg_hs = hs; cfg_se0_filter = filt; cfg_fixed_end = fix; cfg_gap_add = g;
    tx_done = 1'b1;
    for (int k = 1; k <= 28; k++) begin
      @(negedge clk);
      if (eop_pulse) begin n_eop++; if (eop_at < 0) eop_at = k - 1; end
      if (gap_done)  begin n_gap++; if (gap_at < 0) gap_at = k - 1; end
      tx_done    = (k == extra_k);
      line_state = (k <= 8) ? pat[2*(k-1) +: 2] : J;
      if (k == chg_k) begin
        cfg_hs = ~hs; cfg_se0_filter = ~filt; cfg_fixed_end = ~fix; cfg_gap_add = 3'd7;
      end
    end
    tx_done = 1'b0; line_state = J;
    check_int(tag, "eop edge", eop_at, e_eop);
    check_int(tag, "eop count", n_eop, 1);
    check_int("R6", "gap edge", gap_at, e_eop + BASE_GAP + int'(g));
    check_int("R6", "gap count", n_gap, 1);
  endtask

  initial begin
    #(200000.0 * 5.0);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n_eop;
    rst = 1'b1; tx_done = 1'b0; line_state = J;
    cfg_hs = 1'b0; cfg_se0_filter = 1'b0; cfg_fixed_end = 1'b0; cfg_gap_add = 3'd0;
    repeat (3) @(negedge clk);
    check_int("R10", "eop in reset", int'(eop_pulse), 0);
    check_int("R10", "gap in reset", int'(gap_done), 0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk: R1..R4 and R6.
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = VECS[i].hs ? (VECS[i].fix ? "R4" : "R3") : (VECS[i].filt ? "R2" : "R1");
      run_pkt(VECS[i].hs, VECS[i].filt, VECS[i].fix, VECS[i].gap, VECS[i].pat,
              0, 0, int'(VECS[i].e_eop), tag);
    end

    // R1: SE0 with no packet in flight gives nothing.
    n_eop = 0;
    line_state = SE0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (eop_pulse || gap_done) n_eop++; end
    line_state = J;
    check_int("R1", "pulses while idle", n_eop, 0);

    // R5: fixed delay ignored at FS, filter ignored at HS.
    run_pkt(1'b0, 1'b0, 1'b1, 3'd0, pat8(K, SE0, J, J, J, J, J, J), 0, 0, 2, "R5");
    run_pkt(1'b1, 1'b1, 1'b0, 3'd2, pat8(J, SE0, J, J, J, J, J, J), 0, 0, 2, "R5");

    // R9: SE1 is never an end.
    run_pkt(1'b0, 1'b0, 1'b0, 3'd0, pat8(SE1, SE1, K, SE0, J, J, J, J), 0, 0, 4, "R9");
    run_pkt(1'b1, 1'b0, 1'b0, 3'd0, pat8(J, SE1, J, SE0, J, J, J, J), 0, 0, 4, "R9");
    run_pkt(1'b0, 1'b1, 1'b0, 3'd0, pat8(SE1, SE0, SE0, J, J, J, J, J), 0, 0, 3, "R9");

    // R7: configuration change mid-packet has no effect.
    run_pkt(1'b0, 1'b0, 1'b0, 3'd0, pat8(K, SE0, J, J, J, J, J, J), 1, 0, 2, "R7");
    run_pkt(1'b1, 1'b0, 1'b1, 3'd1, pat8(J, J, J, J, J, J, J, J), 2, 0, 5, "R7");

    // R8: strobe during end detection and during the gap is ignored.
    run_pkt(1'b1, 1'b0, 1'b1, 3'd0, pat8(J, J, J, J, J, J, J, J), 0, 3, 5, "R8");
    run_pkt(1'b1, 1'b0, 1'b1, 3'd0, pat8(J, J, J, J, J, J, J, J), 0, 7, 5, "R8");

    // R10: reset mid-packet leaves no pending pulse.
    @(negedge clk);
    cfg_hs = 1'b0; cfg_se0_filter = 1'b0; cfg_fixed_end = 1'b0; cfg_gap_add = 3'd0;
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; line_state = K; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; line_state = SE0;
    n_eop = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (eop_pulse || gap_done) n_eop++; end
    line_state = J;
    check_int("R10", "pulses after reset mid-packet", n_eop, 0);

    // R10: block is idle again and accepts a packet.
    run_pkt(1'b0, 1'b0, 1'b0, 3'd2, pat8(K, K, SE0, J, J, J, J, J), 0, 0, 3, "R10");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule